// File: doc/BRIEF.md
# Undervoltage Reset Sequencer

This block is the digital control that sits behind an analog supply-undervoltage comparator. It takes the raw comparator output and brings it into the clock domain. On a detection it sets a sticky status bit that software can read and clear, and it raises a reset request toward the chip's reset-distribution logic. It also raises a wake signal so that a part sleeping in stop mode is released when the supply sags.

The request is not sent out blindly. If a RAM write is in flight when the undervoltage is seen, the request is parked until the write has finished, so that a memory word is never left half-written. A parked request is latched, so a detection that disappears before the write ends still produces a reset. While any other internal reset is already being driven, this block's own request is masked at its output. Once a request has started, it stays pending for a programmable number of unmasked cycles after the last detection. This gives the downstream reset logic time to latch it.

Top module: `uvr_sequencer`

## Requirements
- R1: While `rst_n_i` is low, and until the first detection after its release, `flag_o`, `rst_req_o` and `stop_wake_o` are all 0.
- R2: A high level on `lv_raw_i` goes through a `SYNC_STAGES`-flop synchronizer (default 2). `flag_o` becomes 1 on the third rising edge after `lv_raw_i` is set up, and not before.
- R3: `flag_o` is sticky. It stays 1 after the low-voltage input returns low, and a register write with `reg_wdata_i` = 1 leaves it unchanged.
- R4: A register write (`reg_wr_en_i` = 1) with `reg_wdata_i` = 0 clears `flag_o` on the next edge. If a synchronized detection is active in the same cycle, the set wins and `flag_o` stays 1.
- R5: `int_rst_active_i` never clears `flag_o`. Only `rst_n_i` and a register write of 0 clear it.
- R6: When no RAM write is in progress, `rst_req_o` rises on the same edge as `flag_o`, which is the third edge after `lv_raw_i` is set up.
- R7: If `ram_wr_busy_i` is 1 when a detection is seen, `rst_req_o` stays 0 while the write continues. It rises on the edge that ends the first cycle with `ram_wr_busy_i` = 0. This holds even if the detection has already gone away.
- R8: In any cycle where `int_rst_active_i` is 1, `rst_req_o` is 0 in that same cycle.
- R9: After the last cycle with an active synchronized detection, the request stays pending for `HOLD_CYCLES` cycles (default 2) in which `int_rst_active_i` is 0. Masked cycles do not count toward this.
- R10: While `stop_mode_i` is 1, `stop_wake_o` is 1 whenever a detection is parked or a request is pending. Detection keeps working in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Power-on reset, asynchronous, active low |
| lv_raw_i | input | 1 | Raw undervoltage indication from the comparator (asynchronous) |
| ram_wr_busy_i | input | 1 | A RAM write cycle is in progress |
| stop_mode_i | input | 1 | The chip is in stop mode |
| int_rst_active_i | input | 1 | An internal reset from any source is being driven |
| reg_wr_en_i | input | 1 | Write strobe for the status bit |
| reg_wdata_i | input | 1 | Write data for the status bit (0 clears it) |
| flag_o | output | 1 | Sticky undervoltage status bit, readable by software |
| rst_req_o | output | 1 | Internal reset request |
| stop_wake_o | output | 1 | Stop-mode release |

## Verification
The status bit and the request both appear three rising edges after the raw input is set up: two edges for the synchronizer and one for the state register. A clearing write shows on the next edge. The masking by another reset acts within the same cycle. A parked request rises one edge after the first idle RAM cycle. A pending request falls `HOLD_CYCLES` unmasked cycles after the detection ends. The bench drives all inputs just after a falling edge, counts rising edges from that point, and samples on the following falling edge, or 1 ns after a drive for the combinational mask. Each check is therefore placed on the exact cycle where the result is first due, and on the one before it.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  // Sequencer states: idle, detection parked behind a RAM write, request pending
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic in_bit;
      if (g == 0) begin : g_first
        assign in_bit = d_i;
      end else begin : g_next
        assign in_bit = chain_q[g-1];
      end
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q[g] <= 1'b0;
        else          chain_q[g] <= in_bit;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uvr_flag.sv
module uvr_flag (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  // set has priority over a software clear in the same cycle
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/uvr_gate.sv
module uvr_gate
  import uvr_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       det_i,
  input  logic       busy_i,
  input  logic       mask_i,
  output seq_state_e state_o,
  output logic       req_o
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (det_i) begin
          if (busy_i) begin
            state_d = SEQ_WAIT;
          end else begin
            state_d = SEQ_HOLD;
            cnt_d   = RELOAD;
          end
        end
      end
      SEQ_WAIT: begin
        if (!busy_i) begin
          state_d = SEQ_HOLD;
          cnt_d   = RELOAD;
        end
      end
      SEQ_HOLD: begin
        if (det_i) begin
          cnt_d = RELOAD;
        end else if (!mask_i) begin
          if (cnt_q == '0) state_d = SEQ_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign req_o   = (state_q == SEQ_HOLD) & ~mask_i;

endmodule

// File: rtl/uvr_sequencer.sv
module uvr_sequencer
  import uvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic lv_raw_i,
  input  logic ram_wr_busy_i,
  input  logic stop_mode_i,
  input  logic int_rst_active_i,
  input  logic reg_wr_en_i,
  input  logic reg_wdata_i,
  output logic flag_o,
  output logic rst_req_o,
  output logic stop_wake_o
);

  logic       rst_n_sync;
  logic       lv_det;
  logic       sw_clear;
  logic       in_hold;
  logic       seq_busy;
  seq_state_e seq_state;

  // asynchronous assertion, synchronous release of the power-on reset
  uvr_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (1'b1),
    .q_o    (rst_n_sync)
  );

  uvr_sync #(.STAGES(SYNC_STAGES)) u_lv_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_sync),
    .d_i    (lv_raw_i),
    .q_o    (lv_det)
  );

  assign sw_clear = reg_wr_en_i & ~reg_wdata_i;

  uvr_flag u_flag (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_sync),
    .set_i  (lv_det),
    .clr_i  (sw_clear),
    .flag_o (flag_o)
  );

  uvr_gate #(.HOLD_CYCLES(HOLD_CYCLES)) u_gate (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_sync),
    .det_i  (lv_det),
    .busy_i (ram_wr_busy_i),
    .mask_i (int_rst_active_i),
    .state_o(seq_state),
    .req_o  (rst_req_o)
  );

  assign in_hold     = (seq_state == SEQ_HOLD);
  assign seq_busy    = (seq_state != SEQ_IDLE);
  assign stop_wake_o = stop_mode_i & seq_busy;

endmodule

// File: rtl/uvr_sequencer_chk.sv
module uvr_sequencer_chk #(
  parameter int HOLD_CYCLES = 2
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic lv_det,
  input logic in_hold,
  input logic seq_busy,
  input logic ram_wr_busy_i,
  input logic stop_mode_i,
  input logic int_rst_active_i,
  input logic reg_wr_en_i,
  input logic reg_wdata_i,
  input logic flag_o,
  input logic rst_req_o,
  input logic stop_wake_o
);

  // R8
  a_r8_mask_forces_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    int_rst_active_i |-> !rst_req_o);

  // R3
  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (flag_o && !(reg_wr_en_i && !reg_wdata_i)) |=> flag_o);

  // R4
  a_r4_clear_on_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (reg_wr_en_i && !reg_wdata_i && !lv_det) |=> !flag_o);

  // R6
  a_r6_req_follows_detect: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (lv_det && !seq_busy && !ram_wr_busy_i) |=> (rst_req_o || int_rst_active_i));

  // R7
  a_r7_no_start_during_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(in_hold) |-> !$past(ram_wr_busy_i));

  // R10
  a_r10_wake_in_stop: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (stop_mode_i && rst_req_o) |-> stop_wake_o);

  // R9
  generate
    if (HOLD_CYCLES > 1) begin : g_hold
      a_r9_min_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_req_o) |=> (rst_req_o || int_rst_active_i));
    end
  endgenerate

endmodule

bind uvr_sequencer uvr_sequencer_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i           (clk_i),
  .rst_n_i         (rst_n_i),
  .lv_det          (lv_det),
  .in_hold         (in_hold),
  .seq_busy        (seq_busy),
  .ram_wr_busy_i   (ram_wr_busy_i),
  .stop_mode_i     (stop_mode_i),
  .int_rst_active_i(int_rst_active_i),
  .reg_wr_en_i     (reg_wr_en_i),
  .reg_wdata_i     (reg_wdata_i),
  .flag_o          (flag_o),
  .rst_req_o       (rst_req_o),
  .stop_wake_o     (stop_wake_o)
);

// File: tb/uvr_sequencer_tb_top.sv
`timescale 1ns/1ps
module uvr_sequencer_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic lv_raw, ram_busy, stop_mode, int_rst, wr_en, wdata;
  logic flag, req, wake;
  int   n_checks = 0;
  int   n_fails  = 0;

  always #2 clk = ~clk;

  uvr_sequencer #(.SYNC_STAGES(2), .HOLD_CYCLES(2)) dut_i (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .lv_raw_i        (lv_raw),
    .ram_wr_busy_i   (ram_busy),
    .stop_mode_i     (stop_mode),
    .int_rst_active_i(int_rst),
    .reg_wr_en_i     (wr_en),
    .reg_wdata_i     (wdata),
    .flag_o          (flag),
    .rst_req_o       (req),
    .stop_wake_o     (wake)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raw input high for one cycle starting now (a negedge); returns after edge 1
  task automatic pulse_raw();
    lv_raw = 1'b1;
    tick(1);
    lv_raw = 1'b0;
  endtask

  task automatic sw_write(input logic v);
    wr_en = 1'b1; wdata = v;
    tick(1);
    wr_en = 1'b0; wdata = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag in reset", flag, 1'b0);
    chk("R1 req in reset", req, 1'b0);
    chk("R1 wake in reset", wake, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 flag after release", flag, 1'b0);
    chk("R1 req after release", req, 1'b0);
  endtask

  task automatic t_basic();
    pulse_raw();                       // edge 1 done
    tick(1);                           // edge 2
    chk("R2 flag not before third edge", flag, 1'b0);
    chk("R6 req not before third edge", req, 1'b0);
    tick(1);                           // edge 3
    chk("R2 flag on third edge", flag, 1'b1);
    chk("R6 req on third edge", req, 1'b1);
    tick(1);                           // edge 4
    chk("R9 req held second cycle", req, 1'b1);
    tick(1);                           // edge 5
    chk("R9 req released after hold", req, 1'b0);
    chk("R3 flag sticky after input low", flag, 1'b1);
    tick(2);
  endtask

  task automatic t_write();
    sw_write(1'b1);
    chk("R3 write of 1 keeps flag", flag, 1'b1);
    sw_write(1'b0);
    chk("R4 write of 0 clears flag", flag, 1'b0);
    tick(2);
  endtask

  task automatic t_race();
    pulse_raw();                       // edge 1
    tick(1);                           // edge 2, detection active in cycle 2-3
    wr_en = 1'b1; wdata = 1'b0;
    tick(1);                           // edge 3
    wr_en = 1'b0;
    chk("R4 set wins over clear", flag, 1'b1);
    tick(4);
    sw_write(1'b0);
    chk("R4 clear after race", flag, 1'b0);
    tick(2);
  endtask

  task automatic t_keep_flag();
    pulse_raw();
    tick(6);                           // request done, flag set
    int_rst = 1'b1;
    tick(4);
    chk("R5 flag kept through internal reset", flag, 1'b1);
    int_rst = 1'b0;
    tick(1);
    chk("R5 flag kept after internal reset", flag, 1'b1);
    sw_write(1'b0);
    tick(2);
  endtask

  task automatic t_defer();
    ram_busy = 1'b1;
    pulse_raw();                       // edge 1
    tick(2);                           // edge 3
    chk("R7 flag set during write", flag, 1'b1);
    chk("R7 req held during write", req, 1'b0);
    tick(3);                           // edge 6, detection long gone
    chk("R7 req still held", req, 1'b0);
    ram_busy = 1'b0;
    tick(1);                           // edge 7
    chk("R7 req after write ends", req, 1'b1);
    tick(1);                           // edge 8
    chk("R9 deferred req held", req, 1'b1);
    tick(1);                           // edge 9
    chk("R9 deferred req released", req, 1'b0);
    sw_write(1'b0);
    tick(2);
  endtask

  task automatic t_mask();
    pulse_raw();                       // edge 1
    tick(2);                           // edge 3
    chk("R6 req before mask", req, 1'b1);
    int_rst = 1'b1;
    #1;
    chk("R8 mask same cycle", req, 1'b0);
    tick(3);                           // edge 6
    chk("R8 masked over cycles", req, 1'b0);
    int_rst = 1'b0;
    #1;
    chk("R9 req back after mask", req, 1'b1);
    tick(1);                           // edge 7
    chk("R9 masked cycles not counted", req, 1'b1);
    tick(1);                           // edge 8
    chk("R9 released after unmasked hold", req, 1'b0);
    sw_write(1'b0);
    tick(2);
  endtask

  task automatic t_stop();
    stop_mode = 1'b1;
    tick(1);
    chk("R10 no wake when idle", wake, 1'b0);
    pulse_raw();                       // edge 1
    tick(1);                           // edge 2
    chk("R10 no wake before detect", wake, 1'b0);
    tick(1);                           // edge 3
    chk("R10 wake on detect in stop", wake, 1'b1);
    chk("R10 req in stop", req, 1'b1);
    chk("R10 flag in stop", flag, 1'b1);
    tick(2);                           // edge 5
    chk("R10 wake ends with request", wake, 1'b0);
    stop_mode = 1'b0;
    sw_write(1'b0);
    tick(2);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lv_raw = 1'b0; ram_busy = 1'b0; stop_mode = 1'b0;
    int_rst = 1'b0; wr_en = 1'b0; wdata = 1'b0;
    tick(3);
    t_reset();
    t_basic();
    t_write();
    t_race();
    t_keep_flag();
    t_defer();
    t_mask();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule